// File: doc/BRIEF.md
# Delay-Hopped Doublet Pulse Encoder

This block is the baseband encoder on the transmit side of an impulse radio that sends a reference pulse and a signal pulse as a pair. It takes one binary symbol at a time over a valid/ready handshake. For each symbol it produces a fixed number of chip frames, one frame per clock period. In each frame it raises pulse-select lines for an analog pulse generator: one line for the reference pulse at tap zero, and one line for the signal pulse at a delay tap.

The signal tap changes from chip to chip according to a per-user delay code. The signal polarity is the product of the symbol and a per-user chip code. Both codes sit in loadable registers. Software or a neighbouring block writes them while no symbol is in flight.

The twelve outputs are split into a positive group and a negative group. Bit j of each group selects a pulse delayed by j half-nanosecond steps. Symbols sent back to back produce an unbroken train of frames.

Top module: `dhop_doublet_encoder`

## Requirements
- R1: While reset is asserted, and after reset, all pulse outputs are low and sym_ready is high.
- R2: A symbol is accepted on a clock edge where sym_valid and sym_ready are both high. sym_ready is low during chips 0 to 6 of a symbol in flight. It is high on the final chip and while idle.
- R3: An accepted symbol yields exactly 8 frames. Chip k (k = 0..7) is presented on the outputs starting k+1 clock edges after the accepting edge.
- R4: In every active frame pos_tap[0] is 1 and neg_tap[0] is 0. The reference pulse is always positive.
- R5: The signal pulse of chip k is positive (a pos_tap bit) when chip_code bit k equals sym_bit, and negative (a neg_tap bit) otherwise. A code or symbol bit of 1 means +1 and 0 means -1.
- R6: The signal pulse of chip k sits at the tap given by the 3-bit delay field dly_code_in[3k+2:3k], for values 1..5. Exactly one of pos_tap[5:1] and neg_tap[5:1] is high in an active frame.
- R7: A delay field value of 0, 6 or 7 is stored as tap 1.
- R8: With no symbol in flight, all twelve outputs stay low.
- R9: A symbol offered while the previous one is in flight is accepted on the previous symbol's final chip. Its first frame follows the previous last frame with no idle cycle.
- R10: A code write (code_we high on a clock edge) takes effect only if no symbol is in flight. A write made during a symbol is dropped, and later symbols keep the old codes.
- R11: After reset the chip code is all +1 and every delay field is tap 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, one chip per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_bit | input | 1 | Symbol value, 1 = +1, 0 = -1 |
| sym_ready | output | 1 | Encoder can take a symbol this cycle |
| code_we | input | 1 | Write the chip code and delay code |
| chip_code_in | input | 8 | Chip code, bit k for chip k, 1 = +1 |
| dly_code_in | input | 24 | Delay code, 3-bit field k for chip k |
| pos_tap | output | 6 | Positive pulse selects, bit j = delay j |
| neg_tap | output | 6 | Negative pulse selects, bit j = delay j |

## Verification
The bench covers delay fields 0, 6 and 7. A design that fails to clamp them would emit no signal pulse, or index a missing tap. It sends symbols back to back and checks both the acceptance spacing and the frame stream. A ready that rises one chip late shows up as a silent frame between symbols. It writes new codes in the middle of a symbol and then sends another symbol. A design that takes the write would change the taps or polarities of that later symbol. Both symbol values are sent against mixed chip codes. A design with the polarity product inverted would swap pos_tap and neg_tap bits.

// File: rtl/dhop_pkg.sv
package dhop_pkg;
  localparam int DLY_W = 3;
  typedef logic [DLY_W-1:0] dly_t;

  function automatic dly_t clamp_dly(dly_t raw, int max_tap);
    if (raw == '0 || int'(raw) > max_tap) return dly_t'(1);
    return raw;
  endfunction
endpackage

// File: rtl/dhop_code_regs.sv
module dhop_code_regs
  import dhop_pkg::*;
#(
  parameter int NUM_CHIPS = 8,
  parameter int MAX_TAP   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       busy,
  input  logic [NUM_CHIPS-1:0]       chip_in,
  input  logic [NUM_CHIPS*DLY_W-1:0] dly_in,
  output logic [NUM_CHIPS-1:0]       chip_q,
  output logic [NUM_CHIPS*DLY_W-1:0] dly_q
);
  logic                       load;
  logic [NUM_CHIPS-1:0]       chip_n;
  logic [NUM_CHIPS*DLY_W-1:0] dly_n;

  assign load = wr_en & ~busy;

  always_comb begin
    chip_n = chip_q;
    if (load) chip_n = chip_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chip_q <= '1;
    else if (load) chip_q <= chip_n;
  end

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_dly
    always_comb begin
      dly_n[i*DLY_W +: DLY_W] = dly_q[i*DLY_W +: DLY_W];
      if (load) dly_n[i*DLY_W +: DLY_W] = clamp_dly(dly_in[i*DLY_W +: DLY_W], MAX_TAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dly_q[i*DLY_W +: DLY_W] <= dly_t'(1);
      else if (load) dly_q[i*DLY_W +: DLY_W] <= dly_n[i*DLY_W +: DLY_W];
    end

    // R6 R7: a stored delay field always names a real signal tap
    p_dly_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q[i*DLY_W +: DLY_W] != '0) && (int'(dly_q[i*DLY_W +: DLY_W]) <= MAX_TAP));
  end

  // R10: codes never move while a symbol is in flight
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(chip_q) && $stable(dly_q));
endmodule

// File: rtl/dhop_chip_seq.sv
module dhop_chip_seq #(
  parameter int NUM_CHIPS = 8,
  localparam int CNT_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             sym_bit,
  output logic             sym_ready,
  output logic             act_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             sym_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_CHIPS - 1);

  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             sym_q;
  logic             last, accept;

  assign last      = act_q && (cnt_q == LAST);
  assign sym_ready = ~act_q | last;
  assign accept    = sym_valid & sym_ready;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (accept) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (act_q) begin
      if (last) act_n = 1'b0;
      else      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sym_q <= 1'b0;
    else if (accept) sym_q <= sym_bit;
  end

  assign act_o = act_q;
  assign idx_o = cnt_q;
  assign sym_o = sym_q;

  // R2: no acceptance before the final chip
  p_ready_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != LAST) |-> !sym_ready);

  // R3 R9: an accepted symbol always restarts at chip 0
  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (act_q && cnt_q == '0));

  // R3: chips advance one per cycle
  p_chip_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != LAST) |=> (act_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dhop_pulse_map.sv
module dhop_pulse_map
  import dhop_pkg::*;
#(
  parameter int NUM_CHIPS = 8,
  parameter int MAX_TAP   = 5,
  localparam int CNT_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_i,
  input  logic [CNT_W-1:0]           idx_i,
  input  logic                       sym_i,
  input  logic [NUM_CHIPS-1:0]       chip_q,
  input  logic [NUM_CHIPS*DLY_W-1:0] dly_q,
  output logic [MAX_TAP:0]           pos_tap,
  output logic [MAX_TAP:0]           neg_tap
);
  logic             chip_bit, pol_pos;
  dly_t             tap;
  logic [MAX_TAP:0] sig_vec;
  logic [MAX_TAP:0] pos_d, neg_d, pos_q, neg_q;

  assign chip_bit = chip_q[idx_i];
  assign tap      = dly_q[int'(idx_i)*DLY_W +: DLY_W];
  assign pol_pos  = ~(chip_bit ^ sym_i);

  assign sig_vec[0] = 1'b0;
  for (genvar t = 1; t <= MAX_TAP; t++) begin : g_tap
    assign sig_vec[t] = (int'(tap) == t);
  end

  always_comb begin
    pos_d = '0;
    neg_d = '0;
    if (act_i) begin
      pos_d[0] = 1'b1;
      if (pol_pos) pos_d = pos_d | sig_vec;
      else         neg_d = sig_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign pos_tap = pos_q;
  assign neg_tap = neg_q;

  // R4: reference pulse only on the positive tap zero
  p_ref_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pos_q, neg_q}) |-> (pos_q[0] && !neg_q[0]));

  // R6: a single signal pulse per active frame
  p_sig_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pos_q, neg_q}) |-> ($countones({pos_q[MAX_TAP:1], neg_q[MAX_TAP:1]}) == 1));

  // R8: quiet output after an idle cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> (pos_q == '0 && neg_q == '0));
endmodule

// File: rtl/dhop_doublet_encoder.sv
module dhop_doublet_encoder
  import dhop_pkg::*;
#(
  parameter int NUM_CHIPS = 8,
  parameter int MAX_TAP   = 5,
  localparam int CNT_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sym_valid,
  input  logic                       sym_bit,
  output logic                       sym_ready,
  input  logic                       code_we,
  input  logic [NUM_CHIPS-1:0]       chip_code_in,
  input  logic [NUM_CHIPS*DLY_W-1:0] dly_code_in,
  output logic [MAX_TAP:0]           pos_tap,
  output logic [MAX_TAP:0]           neg_tap
);
  logic                       act;
  logic [CNT_W-1:0]           idx;
  logic                       sym;
  logic [NUM_CHIPS-1:0]       chip_q;
  logic [NUM_CHIPS*DLY_W-1:0] dly_q;

  dhop_chip_seq #(.NUM_CHIPS(NUM_CHIPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit),
    .sym_ready(sym_ready), .act_o(act), .idx_o(idx), .sym_o(sym)
  );

  dhop_code_regs #(.NUM_CHIPS(NUM_CHIPS), .MAX_TAP(MAX_TAP)) u_codes (
    .clk(clk), .rst_n(rst_n), .wr_en(code_we), .busy(act),
    .chip_in(chip_code_in), .dly_in(dly_code_in),
    .chip_q(chip_q), .dly_q(dly_q)
  );

  dhop_pulse_map #(.NUM_CHIPS(NUM_CHIPS), .MAX_TAP(MAX_TAP)) u_map (
    .clk(clk), .rst_n(rst_n), .act_i(act), .idx_i(idx), .sym_i(sym),
    .chip_q(chip_q), .dly_q(dly_q), .pos_tap(pos_tap), .neg_tap(neg_tap)
  );

  // R1: ready is high once reset has just been applied
  p_reset_ready_r1: assert property (@(posedge clk)
    !rst_n |-> sym_ready);
endmodule

// File: tb/tb_dhop_doublet_encoder.sv
`timescale 1ns/1ps
module tb_dhop_doublet_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0, sym_bit = 1'b0, code_we = 1'b0;
  logic [7:0]  chip_code_in = '0;
  logic [23:0] dly_code_in = '0;
  logic        sym_ready;
  logic [5:0]  pos_tap, neg_tap;

  dhop_doublet_encoder dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_bit(sym_bit),
    .sym_ready(sym_ready), .code_we(code_we), .chip_code_in(chip_code_in),
    .dly_code_in(dly_code_in), .pos_tap(pos_tap), .neg_tap(neg_tap)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_on = 1'b0;
  logic [7:0] m_chip = 8'hFF;
  int         m_dly[8] = '{1, 1, 1, 1, 1, 1, 1, 1};

  int         q_cyc[$];
  logic [11:0] q_val[$];
  string      q_tag[$];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int clampd(int v);
    return (v < 1 || v > 5) ? 1 : v;
  endfunction

  task automatic load_codes(logic [7:0] c, int d[8], bit taken);
    logic [23:0] f;
    for (int k = 0; k < 8; k++) f[k*3 +: 3] = 3'(d[k]);
    code_we = 1'b1; chip_code_in = c; dly_code_in = f;
    @(posedge clk);
    @(negedge clk);
    code_we = 1'b0;
    if (taken) begin
      m_chip = c;
      for (int k = 0; k < 8; k++) m_dly[k] = clampd(d[k]);
    end
  endtask

  // driver: offer a symbol, push its expected frames once accepted
  task automatic send_sym(bit b, string tag, output int acc);
    int a;
    sym_valid = 1'b1; sym_bit = b;
    while (!sym_ready) @(negedge clk);
    a = cyc + 1;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      logic pol;
      logic [5:0] p, n;
      pol = (m_chip[k] == b);
      p = 6'b000001; n = '0;
      if (pol) p[m_dly[k]] = 1'b1; else n[m_dly[k]] = 1'b1;
      q_cyc.push_back(a + 1 + k);
      q_val.push_back({p, n});
      q_tag.push_back(tag);
    end
    acc = a;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  // monitor: compare each frame against the scoreboard head
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        logic [11:0] e;
        string t;
        e = q_val.pop_front(); t = q_tag.pop_front(); void'(q_cyc.pop_front());
        check(pos_tap[0] == 1'b1 && neg_tap[0] == 1'b0, {t, " R4 ref"}, {pos_tap, neg_tap}, e);
        check({pos_tap[5:1], neg_tap[5:1]} == {e[11:7], e[5:1]}, {t, " R3 R5 R6 signal"}, {pos_tap, neg_tap}, e);
      end else begin
        check(pos_tap == '0 && neg_tap == '0, "R8 idle", {pos_tap, neg_tap}, 0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a0, a1, a2;
    int dA[8] = '{5, 4, 3, 2, 1, 5, 3, 2};
    int dB[8] = '{0, 6, 7, 4, 2, 1, 7, 5};
    int dC[8] = '{2, 3, 4, 5, 1, 2, 3, 4};
    repeat (3) @(negedge clk);
    check(pos_tap == '0 && neg_tap == '0, "R1 outputs in reset", {pos_tap, neg_tap}, 0);
    check(sym_ready == 1'b1, "R1 ready in reset", sym_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(sym_ready == 1'b1, "R1 ready after reset", sym_ready, 1);
    mon_on = 1'b1;
    repeat (4) @(negedge clk);

    send_sym(1'b1, "R11", a0);
    repeat (10) @(negedge clk);
    send_sym(1'b0, "R11", a0);
    repeat (10) @(negedge clk);

    load_codes(8'b1011_0010, dA, 1'b1);
    send_sym(1'b1, "R5", a0);
    repeat (9) @(negedge clk);
    send_sym(1'b0, "R6", a0);
    repeat (9) @(negedge clk);

    load_codes(8'b0110_1001, dB, 1'b1);
    send_sym(1'b1, "R7", a0);
    repeat (9) @(negedge clk);

    // R2: ready low on chips 0..6, high on the final chip
    sym_valid = 1'b1; sym_bit = 1'b0;
    a0 = cyc + 1;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      logic pol;
      logic [5:0] p, n;
      pol = (m_chip[k] == 1'b0);
      p = 6'b000001; n = '0;
      if (pol) p[m_dly[k]] = 1'b1; else n[m_dly[k]] = 1'b1;
      q_cyc.push_back(a0 + 1 + k); q_val.push_back({p, n}); q_tag.push_back("R2");
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sym_valid = 1'b0;
      check(sym_ready == (k == 7), "R2 ready during symbol", sym_ready, (k == 7));
    end
    repeat (4) @(negedge clk);

    // R9: three symbols offered back to back
    send_sym(1'b1, "R9", a0);
    send_sym(1'b0, "R9", a1);
    check(a1 - a0 == 8, "R9 accept spacing", a1 - a0, 8);
    send_sym(1'b1, "R9", a2);
    check(a2 - a1 == 8, "R9 accept spacing", a2 - a1, 8);
    repeat (10) @(negedge clk);

    // R10: write during a symbol is dropped, write while idle is taken
    send_sym(1'b1, "R10", a0);
    load_codes(8'b0000_1111, dC, 1'b0);
    repeat (9) @(negedge clk);
    send_sym(1'b0, "R10", a0);
    repeat (9) @(negedge clk);
    load_codes(8'b0000_1111, dC, 1'b1);
    send_sym(1'b0, "R10", a0);
    repeat (12) @(negedge clk);

    check(q_cyc.size() == 0, "R3 all frames seen", q_cyc.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule